// File: doc/BRIEF.md
# Codec register access controller

This block sits on a processor's register bus and lets software reach one register inside an external audio codec at a time. Software first loads the codec register number and, for a write, the outgoing value. It then writes the control word with the request flag set. The direction flag in that same write selects the kind of access. The block never stores the request flag. Instead it turns each accepted request into a single-cycle event on one of two separate lines: one line for codec writes and one for codec reads. A link engine downstream uses these lines, together with the registered codec address, outgoing data and direction, to run the serial exchange.

The codec side returns read results through a reply strobe, which loads the incoming-data register. Software then reads that register back. Offsets above the four codec words belong to other functions that share the same decode, so this block answers them with zero and ignores writes to them. Requests that arrive back to back are all accepted. Each event line then issues them one by one, with at least one idle cycle between pulses.

Top module: `codec_cfg_ctrl`

## Requirements
- R1: After reset every register reads as zero, both event lines are low and the codec address, outgoing data and direction outputs are zero.
- R2: The word index is taken from byte address bits above bit 1. Index 0 (0x00) is control, index 1 (0x04) is codec address, index 2 (0x08) is outgoing data and index 3 (0x0C) is incoming data. Address bits [1:0] are ignored. The address, outgoing-data and incoming-data registers read back all 32 written bits. Read data appears on `bus_rdata` in the cycle after `bus_rd_en`.
- R3: Control bit 0 is the request flag and always reads back as 0. Every other control bit reads back as written.
- R4: A control write with bit 0 = 1 and bit 1 = 1 (codec write) raises `irq_wr_done` for exactly one cycle, starting the cycle after the write. `irq_rd_reply` stays low.
- R5: A control write with bit 0 = 1 and bit 1 = 0 (codec read) raises `irq_rd_reply` for exactly one cycle, starting the cycle after the write. `irq_wr_done` stays low.
- R6: A control write with bit 0 = 0 raises no event.
- R7: Only accesses with all four byte enables set (`bus_be` = 4'b1111) are valid. Any other access leaves all registers unchanged and reads back as zero.
- R8: Offsets at index 4 and above read back as zero. Writes to them change no register.
- R9: `rsp_strobe` loads the incoming-data register with `rsp_data`, zero-extended. If a bus write to that register happens in the same cycle, the strobe wins.
- R10: Requests on consecutive cycles are all accepted. Each event line never stays high for two cycles in a row. Up to 2^PEND_W-1 requests wait to be pulsed, so a burst of N requests yields N pulses.
- R11: `codec_addr`, `codec_wdata` and `codec_write` carry the low bits of the codec address register, the low bits of the outgoing-data register, and control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address in the register window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| rsp_strobe | input | 1 | Codec reply strobe |
| rsp_data | input | CODEC_DATA_W | Codec reply value |
| codec_addr | output | CODEC_ADDR_W | Codec register number |
| codec_wdata | output | CODEC_DATA_W | Value to write into the codec |
| codec_write | output | 1 | Direction of the current request (1 = write) |
| irq_wr_done | output | 1 | One-cycle event for a codec write request |
| irq_rd_reply | output | 1 | One-cycle event for a codec read request |

## Verification
The bench builds the block with ADDR_W = 6, which gives a sixteen-word window. Offsets such as 0x14 and 0x3C are then reachable, so the zero-read and ignored-write behaviour of the shared decode can be observed. It uses PEND_W = 2, so a five-request burst builds a backlog of two without saturating. This shows that every request turns into a separate pulse. The codec widths of 7 and 16 bits make truncation of the codec outputs and zero-extension of the reply visible in wide test patterns.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
  localparam int NUM_REGS     = 4;
  localparam int CTRL_REQ_BIT = 0;
  localparam int CTRL_DIR_BIT = 1;

  typedef enum logic [1:0] {
    IDX_CTRL  = 2'd0,
    IDX_CADDR = 2'd1,
    IDX_DOUT  = 2'd2,
    IDX_DIN   = 2'd3
  } reg_idx_e;

  // event vector slots: one per output line
  localparam int EV_WR = 0;
  localparam int EV_RD = 1;
  localparam int NUM_EV = 2;
endpackage

// File: rtl/codec_cfg_decode.sv
module codec_cfg_decode
  import codec_cfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:2] word_addr,
  input  logic [3:0]        be,
  output logic              hit,
  output reg_idx_e          idx
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] NREG = IDX_W'(NUM_REGS);

  logic [IDX_W-1:0] word_idx;
  assign word_idx = word_addr;

  // full-word access inside the codec words only
  assign hit = (be == 4'b1111) && (word_idx < NREG);
  assign idx = reg_idx_e'(word_idx[1:0]);
endmodule

// File: rtl/codec_cfg_regs.sv
module codec_cfg_regs
  import codec_cfg_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CODEC_DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  reg_idx_e                idx,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    rsp_strobe,
  input  logic [CODEC_DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0]       regs_o [NUM_REGS],
  output logic [NUM_EV-1:0]       req_ev
);
  localparam logic [DATA_W-1:0] REQ_MASK = DATA_W'(1) << CTRL_REQ_BIT;

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];
  logic [DATA_W-1:0] din_ext;
  logic              ctrl_wr;

  assign din_ext = {{(DATA_W-CODEC_DATA_W){1'b0}}, rsp_data};
  assign ctrl_wr = wr_en && (idx == IDX_CTRL);

  // request flag is consumed at once and never stored
  assign req_ev[EV_WR] = ctrl_wr && wdata[CTRL_REQ_BIT] && wdata[CTRL_DIR_BIT];
  assign req_ev[EV_RD] = ctrl_wr && wdata[CTRL_REQ_BIT] && !wdata[CTRL_DIR_BIT];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      regs_d[i] = regs_q[i];
      if (wr_en && (idx == reg_idx_e'(i))) begin
        regs_d[i] = (i == int'(IDX_CTRL)) ? (wdata & ~REQ_MASK) : wdata;
      end
    end
    // codec reply has priority over a bus write
    if (rsp_strobe) regs_d[IDX_DIN] = din_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_o[i] = regs_q[i];
  end
endmodule

// File: rtl/codec_cfg_pulse.sv
module codec_cfg_pulse #(
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse
);
  localparam logic [PEND_W-1:0] CNT_MAX = '1;

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              pulse_q;
  logic              fire;

  // a new pulse only after a low cycle, so events stay distinct
  assign fire = !pulse_q && (req || (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    unique case ({req, fire})
      2'b10:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= fire;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/codec_cfg_ctrl.sv
module codec_cfg_ctrl
  import codec_cfg_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int CODEC_ADDR_W = 7,
  parameter int CODEC_DATA_W = 16,
  parameter int PEND_W       = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr_en,
  input  logic                    bus_rd_en,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [3:0]              bus_be,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    rsp_strobe,
  input  logic [CODEC_DATA_W-1:0] rsp_data,
  output logic [CODEC_ADDR_W-1:0] codec_addr,
  output logic [CODEC_DATA_W-1:0] codec_wdata,
  output logic                    codec_write,
  output logic                    irq_wr_done,
  output logic                    irq_rd_reply
);
  localparam int DATA_W = 32;

  logic              hit;
  reg_idx_e          idx;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [NUM_EV-1:0] req_ev;
  logic [NUM_EV-1:0] ev_pulse;
  logic              unused_lo;

  assign unused_lo = &{1'b0, bus_addr[1:0]};

  codec_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .word_addr (bus_addr[ADDR_W-1:2]),
    .be        (bus_be),
    .hit       (hit),
    .idx       (idx)
  );

  codec_cfg_regs #(.DATA_W(DATA_W), .CODEC_DATA_W(CODEC_DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr_en && hit),
    .idx        (idx),
    .wdata      (bus_wdata),
    .rsp_strobe (rsp_strobe),
    .rsp_data   (rsp_data),
    .regs_o     (regs),
    .req_ev     (req_ev)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    codec_cfg_pulse #(.PEND_W(PEND_W)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_ev[g]),
      .pulse (ev_pulse[g])
    );
  end

  assign irq_wr_done  = ev_pulse[EV_WR];
  assign irq_rd_reply = ev_pulse[EV_RD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= hit ? regs[idx] : '0;
  end

  assign codec_addr  = regs[IDX_CADDR][CODEC_ADDR_W-1:0];
  assign codec_wdata = regs[IDX_DOUT][CODEC_DATA_W-1:0];
  assign codec_write = regs[IDX_CTRL][CTRL_DIR_BIT];
endmodule

// File: rtl/codec_cfg_ctrl_chk.sv
module codec_cfg_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_rdata,
  input logic              irq_wr_done,
  input logic              irq_rd_reply
);
  // R10: each line drops between two pulses
  a_r10_wr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr_done |=> !irq_wr_done);
  a_r10_rd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rd_reply |=> !irq_rd_reply);

  // R3: request flag never reads back
  a_r3_req_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_be == 4'b1111 && bus_addr[ADDR_W-1:2] == '0)
      |=> !bus_rdata[0]);

  // R7: partial access reads as zero
  a_r7_partial_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_be != 4'b1111) |=> bus_rdata == '0);

  // R8: offsets past the codec words read as zero
  a_r8_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr[ADDR_W-1:4] != '0) |=> bus_rdata == '0);
endmodule

bind codec_cfg_ctrl codec_cfg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rd_en    (bus_rd_en),
  .bus_addr     (bus_addr),
  .bus_be       (bus_be),
  .bus_rdata    (bus_rdata),
  .irq_wr_done  (irq_wr_done),
  .irq_rd_reply (irq_rd_reply)
);

// File: tb/test_codec_cfg_ctrl.sv
`timescale 1ns/1ps
module test_codec_cfg_ctrl;
  localparam int AW = 6;
  localparam int CAW = 7;
  localparam int CDW = 16;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rsp_strobe = 1'b0;
  logic [CDW-1:0] rsp_data = '0;
  logic [CAW-1:0] codec_addr;
  logic [CDW-1:0] codec_wdata;
  logic codec_write, irq_wr_done, irq_rd_reply;

  always #4 clk = ~clk;

  codec_cfg_ctrl #(.ADDR_W(AW), .CODEC_ADDR_W(CAW), .CODEC_DATA_W(CDW), .PEND_W(2)) i_codec_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rsp_strobe(rsp_strobe), .rsp_data(rsp_data), .codec_addr(codec_addr),
    .codec_wdata(codec_wdata), .codec_write(codec_write),
    .irq_wr_done(irq_wr_done), .irq_rd_reply(irq_rd_reply));

  int n_cmp = 0, n_bad = 0;
  int wr_pulses = 0, rd_pulses = 0, doubles = 0;
  logic prev_wr = 1'b0, prev_rd = 1'b0;

  always @(negedge clk) begin
    if (irq_wr_done) wr_pulses++;
    if (irq_rd_reply) rd_pulses++;
    if ((irq_wr_done && prev_wr) || (irq_rd_reply && prev_rd)) doubles++;
    prev_wr = irq_wr_done;
    prev_rd = irq_rd_reply;
  end

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_rd_en = 1'b0; bus_be = 4'hF;
    d = bus_rdata;
  endtask

  typedef struct packed {
    logic        is_rd;
    logic [5:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h04, 4'hF, 32'h0000_1234, 4'd2},  // R2 codec address
    '{1'b1, 6'h04, 4'hF, 32'h0000_1234, 4'd2},
    '{1'b0, 6'h08, 4'hF, 32'hDEAD_BEEF, 4'd2},  // R2 outgoing data
    '{1'b1, 6'h08, 4'hF, 32'hDEAD_BEEF, 4'd2},
    '{1'b0, 6'h0C, 4'hF, 32'hC0DE_5A5A, 4'd2},  // R2 incoming data
    '{1'b1, 6'h0C, 4'hF, 32'hC0DE_5A5A, 4'd2},
    '{1'b0, 6'h00, 4'hF, 32'hF0F0_00F2, 4'd3},  // R3 / R6 no request
    '{1'b1, 6'h00, 4'hF, 32'hF0F0_00F2, 4'd3},
    '{1'b0, 6'h08, 4'h3, 32'h1111_1111, 4'd7},  // R7 partial write
    '{1'b1, 6'h08, 4'hF, 32'hDEAD_BEEF, 4'd7},
    '{1'b1, 6'h08, 4'h3, 32'h0000_0000, 4'd7},  // R7 partial read
    '{1'b0, 6'h14, 4'hF, 32'h0000_0099, 4'd8},  // R8 undecoded write
    '{1'b1, 6'h14, 4'hF, 32'h0000_0000, 4'd8},
    '{1'b1, 6'h04, 4'hF, 32'h0000_1234, 4'd8},
    '{1'b1, 6'h3C, 4'hF, 32'h0000_0000, 4'd8},
    '{1'b1, 6'h06, 4'hF, 32'h0000_1234, 4'd2}   // R2 low bits ignored
  };

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(AW'(i * 4), r);
      chk(1, "reset reg", r, 32'h0);
    end
    chk(1, "reset irq", {30'd0, irq_wr_done, irq_rd_reply}, 32'h0);
    chk(1, "reset codec out", {8'd0, codec_addr, codec_write, codec_wdata}, 32'h0);

    w0 = wr_pulses; r0 = rd_pulses;
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].is_rd) begin
        rd(VEC[v].addr, r, VEC[v].be);
        chk(int'(VEC[v].req), "vector read", r, VEC[v].data);
      end else begin
        wr(VEC[v].addr, VEC[v].data, VEC[v].be);
      end
    end
    repeat (3) @(negedge clk);
    chk(6, "no pulse without request", 32'(wr_pulses - w0 + rd_pulses - r0), 32'h0);

    // R11 codec outputs
    chk(11, "codec_addr", 32'(codec_addr), 32'h34);
    chk(11, "codec_wdata", 32'(codec_wdata), 32'hBEEF);
    chk(11, "codec_write", 32'(codec_write), 32'h1);

    // R4 codec write request
    wr(6'h00, 32'h0000_0003);
    chk(4, "wr_done high", 32'(irq_wr_done), 32'h1);
    chk(4, "rd_reply low", 32'(irq_rd_reply), 32'h0);
    @(negedge clk);
    chk(4, "wr_done one cycle", 32'(irq_wr_done), 32'h0);
    rd(6'h00, r);
    chk(3, "request bit clears", r, 32'h2);

    // R5 codec read request
    wr(6'h00, 32'h0000_0001);
    chk(5, "rd_reply high", 32'(irq_rd_reply), 32'h1);
    chk(5, "wr_done low", 32'(irq_wr_done), 32'h0);
    @(negedge clk);
    chk(5, "rd_reply one cycle", 32'(irq_rd_reply), 32'h0);
    chk(11, "codec_write read dir", 32'(codec_write), 32'h0);

    // R9 reply strobe
    @(negedge clk);
    rsp_strobe = 1'b1; rsp_data = 16'hABCD;
    @(negedge clk);
    rsp_strobe = 1'b0;
    rd(6'h0C, r);
    chk(9, "reply load", r, 32'h0000_ABCD);
    @(negedge clk);
    rsp_strobe = 1'b1; rsp_data = 16'h7777;
    bus_wr_en = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h1111_1111;
    @(negedge clk);
    rsp_strobe = 1'b0; bus_wr_en = 1'b0;
    rd(6'h0C, r);
    chk(9, "strobe beats bus write", r, 32'h0000_7777);

    // R10 burst of five write requests on consecutive cycles
    w0 = wr_pulses; r0 = doubles;
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 6'h00; bus_wdata = 32'h3;
    repeat (5) @(negedge clk);
    bus_wr_en = 1'b0;
    repeat (12) @(negedge clk);
    chk(10, "burst pulse count", 32'(wr_pulses - w0), 32'd5);
    chk(10, "no back-to-back highs", 32'(doubles - r0), 32'd0);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(6'h08, r);
    chk(1, "re-reset data", r, 32'h0);
    chk(1, "re-reset codec_wdata", 32'(codec_wdata), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule